// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Prescaler

This block is a watchdog timer that runs from a dedicated clock-enable input, `tickEn`, rather than from a clock of its own. Each enabled tick feeds a programmable prescaler. The prescaler divides the tick rate by a power of two chosen through a small select register. Each prescaler period advances a fixed-width watchdog counter. When that counter overflows, the block raises a reset request for exactly one clock cycle and sets a sticky timeout flag.

Software must strobe `kick` often enough to keep the counter away from overflow. `kick` zeroes both the prescaler and the counter. Writing the select register changes the division ratio and restarts the prescaler phase, but leaves the counter where it is.

The select value currently in force is readable on `selCur`. The timeout flag can only be cleared by the power-on reset `rstN`, so after a watchdog-initiated restart software can tell that a timeout caused it.

Top module: `wdtPrescaled`

## Requirements
- R1: After `rstN` is asserted, `wdtReset` is 0, `timeoutFlag` is 0 and `selCur` is 7.
- R2: With select value s, the counter advances once per 2^s enabled ticks, where s=0 divides by 1 and s=7 divides by 128. Starting from a clear, the overflow happens on tick number 256·2^s.
- R3: A select write stores only bits [2:0] of `selWrData` into `selCur` on the next clock edge. Bits [7:3] have no effect on `selCur` or on timing. `selCur` changes on no other edge.
- R4: `wdtReset` is high for exactly one cycle, starting in the cycle after the clock edge at which the overflowing tick is taken. At all other times it is low.
- R5: `kick` zeroes both the prescaler and the 8-bit counter. It takes priority over a tick in the same cycle, so that tick is discarded and cannot cause an overflow.
- R6: A select write clears the prescaler but keeps the counter value. A tick in the same cycle as a select write is discarded.
- R7: `timeoutFlag` becomes 1 together with `wdtReset` and stays 1 through kicks and select writes. Only `rstN` clears it.
- R8: While `tickEn` is low, neither the prescaler nor the counter moves, and no reset request is issued.
- R9: After an overflow the counter wraps to 0 and keeps counting. The next overflow comes another 256·2^s ticks later if there is no kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| tickEn | input | 1 | Watchdog clock enable; one tick per high cycle |
| kick | input | 1 | Software clear strobe for prescaler and counter |
| selWrEn | input | 1 | Select register write strobe |
| selWrData | input | 8 | Select write data; only bits [2:0] are used |
| wdtReset | output | 1 | One-cycle reset request on overflow |
| timeoutFlag | output | 1 | Sticky timeout indication |
| selCur | output | 3 | Division select currently in force |

## Verification
The properties assume that every input is a clean synchronous level sampled at the rising edge. They also assume that two overflows are always at least 256 ticks apart, which holds for any select value because the counter restarts from zero. The stimulus changes inputs only on falling edges, so no input is ever sampled mid-transition. Random select writes are held to small values so that random runs actually reach overflow. Random kicks are kept rare enough that some runs expire and others are rescued.

// File: rtl/wdtPkg.sv
package wdtPkg;

  // Strobes issued by the control module to the datapath each cycle.
  typedef struct packed {
    logic selLoad;  // capture low select bits
    logic preClr;   // zero the prescaler
    logic preAdv;   // increment the prescaler
    logic cntClr;   // zero the watchdog counter
    logic cntAdv;   // increment the watchdog counter (wraps)
  } wdtStrobes_t;

endpackage

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import wdtPkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  parameter int SEL_RST = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdtStrobes_t       strobes,
  input  logic [SEL_W-1:0]  selIn,
  output logic [SEL_W-1:0]  selQ,
  output logic              preTerm,
  output logic              cntTerm
);

  // Prescaler wide enough for the largest ratio, 2^(2^SEL_W - 1).
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] preQ;
  logic [PRE_W-1:0] preMask;
  logic [CNT_W-1:0] cntQ;

  // Terminal mask: bit i is set when select exceeds i, i.e. mask = 2^sel - 1.
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign preMask[i] = (selQ > SEL_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= SEL_W'(SEL_RST);
    end else if (strobes.selLoad) begin
      selQ <= selIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
    end else if (strobes.preClr) begin
      preQ <= '0;
    end else if (strobes.preAdv) begin
      preQ <= preQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobes.cntClr) begin
      cntQ <= '0;
    end else if (strobes.cntAdv) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign preTerm = (preQ == preMask);
  assign cntTerm = (cntQ == {CNT_W{1'b1}});

endmodule

// File: rtl/wdtControl.sv
module wdtControl
  import wdtPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        kick,
  input  logic        selWrEn,
  input  logic        preTerm,
  input  logic        cntTerm,
  output wdtStrobes_t strobes,
  output logic        pulseQ,
  output logic        flagQ
);

  logic tickTaken;
  logic overflow;

  // A kick or a select write swallows a coincident tick.
  assign tickTaken = tickEn && !kick && !selWrEn;
  assign overflow  = tickTaken && preTerm && cntTerm;

  always_comb begin
    strobes         = '0;
    strobes.selLoad = selWrEn;
    strobes.preClr  = kick || selWrEn || (tickTaken && preTerm);
    strobes.preAdv  = tickTaken && !preTerm;
    strobes.cntClr  = kick;
    strobes.cntAdv  = tickTaken && preTerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseQ <= 1'b0;
      flagQ  <= 1'b0;
    end else begin
      pulseQ <= overflow;
      if (overflow) flagQ <= 1'b1;
    end
  end

endmodule

// File: rtl/wdtPrescaled.sv
module wdtPrescaled
  import wdtPkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  parameter int SEL_RST = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              kick,
  input  logic              selWrEn,
  input  logic [DATA_W-1:0] selWrData,
  output logic              wdtReset,
  output logic              timeoutFlag,
  output logic [SEL_W-1:0]  selCur
);

  wdtStrobes_t strobes;
  logic        preTerm;
  logic        cntTerm;

  wdtControl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .kick    (kick),
    .selWrEn (selWrEn),
    .preTerm (preTerm),
    .cntTerm (cntTerm),
    .strobes (strobes),
    .pulseQ  (wdtReset),
    .flagQ   (timeoutFlag)
  );

  wdtDatapath #(
    .SEL_W   (SEL_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .SEL_RST (SEL_RST)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .selIn   (selWrData[SEL_W-1:0]),
    .selQ    (selCur),
    .preTerm (preTerm),
    .cntTerm (cntTerm)
  );

endmodule

// File: rtl/wdtPrescaledChk.sv
module wdtPrescaledChk #(
  parameter int SEL_W  = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              kick,
  input logic              selWrEn,
  input logic [DATA_W-1:0] selWrData,
  input logic              wdtReset,
  input logic              timeoutFlag,
  input logic [SEL_W-1:0]  selCur
);

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    wdtReset |=> !wdtReset);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |=> timeoutFlag);

  p_flag_with_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    wdtReset |-> timeoutFlag);

  p_kick_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> !wdtReset);

  p_idle_no_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> !wdtReset);

  p_selwr_no_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    selWrEn |=> !wdtReset);

  p_sel_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    selWrEn |=> (selCur == $past(selWrData[SEL_W-1:0])));

  p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !selWrEn |=> $stable(selCur));

endmodule

bind wdtPrescaled wdtPrescaledChk #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .tickEn      (tickEn),
  .kick        (kick),
  .selWrEn     (selWrEn),
  .selWrData   (selWrData),
  .wdtReset    (wdtReset),
  .timeoutFlag (timeoutFlag),
  .selCur      (selCur)
);

// File: tb/sim_wdtPrescaled.sv
module sim_wdtPrescaled;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       kick = 1'b0;
  logic       selWrEn = 1'b0;
  logic [7:0] selWrData = 8'h00;
  logic       wdtReset;
  logic       timeoutFlag;
  logic [2:0] selCur;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Spec-level expectation state, updated at every rising edge.
  int mSel = 7, mPre = 0, mCnt = 0;
  bit mPulse = 0, mFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdtPrescaled u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .kick(kick),
    .selWrEn(selWrEn), .selWrData(selWrData),
    .wdtReset(wdtReset), .timeoutFlag(timeoutFlag), .selCur(selCur)
  );

  function automatic int ticksToOverflow(int s);
    return 256 * (1 << s);
  endfunction

  always @(posedge clk or negedge rstN) begin
    bit ovf;
    if (!rstN) begin
      mSel = 7; mPre = 0; mCnt = 0; mPulse = 0; mFlag = 0;
    end else begin
      ovf = 0;
      if (kick) begin mPre = 0; mCnt = 0; end
      if (selWrEn) begin mSel = int'(selWrData[2:0]); mPre = 0; end
      if (tickEn && !kick && !selWrEn) begin
        if (mPre == (1 << mSel) - 1) begin
          mPre = 0;
          if (mCnt == 255) ovf = 1;
          mCnt = (mCnt + 1) % 256;
        end else begin
          mPre = mPre + 1;
        end
      end
      mPulse = ovf;
      if (ovf) mFlag = 1;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the expectation model (R3, R4, R7).
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(wdtReset == mPulse, "R4 pulse", int'(wdtReset), int'(mPulse));
      check(timeoutFlag == mFlag, "R7 flag", int'(timeoutFlag), int'(mFlag));
      check(int'(selCur) == mSel, "R3 select", int'(selCur), mSel);
    end
  end

  task automatic writeSel(logic [7:0] d);
    selWrEn = 1; selWrData = d;
    @(negedge clk);
    selWrEn = 0;
  endtask

  task automatic doKick();
    kick = 1;
    @(negedge clk);
    kick = 0;
  endtask

  task automatic runTicks(int n);
    tickEn = 1;
    for (int i = 0; i < n; i++) @(negedge clk);
    tickEn = 0;
  endtask

  // Tick continuously and count edges until the reset request shows.
  task automatic measure(int exp, string req);
    int n = 0;
    tickEn = 1;
    while (n < exp + 10) begin
      @(negedge clk);
      n++;
      if (wdtReset) break;
    end
    tickEn = 0;
    check(n == exp, req, n, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(wdtReset == 0, "R1 pulse", int'(wdtReset), 0);
    check(timeoutFlag == 0, "R1 flag", int'(timeoutFlag), 0);
    check(selCur == 3'd7, "R1 select", int'(selCur), 7);
    rstN = 1;
    @(negedge clk);

    // R2: divide-by-1
    writeSel(8'h00); doKick();
    measure(ticksToOverflow(0), "R2 div1");
    check(timeoutFlag == 1, "R7 set", int'(timeoutFlag), 1);
    // R9: wrap and count again
    measure(ticksToOverflow(0), "R9 rerun");
    // R2: divide-by-4
    writeSel(8'h02); doKick();
    measure(ticksToOverflow(2), "R2 div4");
    // R3: upper bits ignored, 0xF9 behaves as 1
    writeSel(8'hF9); doKick();
    check(selCur == 3'd1, "R3 low bits", int'(selCur), 1);
    measure(ticksToOverflow(1), "R3 timing");

    // R8: counter parked at 255, idle ticks do nothing
    writeSel(8'h00); doKick();
    runTicks(255);
    repeat (300) @(negedge clk);
    check(wdtReset == 0, "R8 idle", int'(wdtReset), 0);
    measure(1, "R8 resume");

    // R5: kick coincident with overflowing tick
    doKick();
    runTicks(255);
    kick = 1; tickEn = 1;
    @(negedge clk);
    kick = 0; tickEn = 0;
    check(wdtReset == 0, "R5 priority", int'(wdtReset), 0);
    check(timeoutFlag == 1, "R7 kick keeps", int'(timeoutFlag), 1);
    measure(ticksToOverflow(0), "R5 restart");

    // R6: select write clears prescaler only
    writeSel(8'h03); doKick();
    runTicks(5);
    writeSel(8'h03);
    measure(ticksToOverflow(3), "R6 prescaler clear");
    writeSel(8'h00); doKick();
    runTicks(100);
    writeSel(8'h00);
    measure(ticksToOverflow(0) - 100, "R6 counter kept");

    // R7: only power-on reset clears the flag
    rstN = 0;
    @(negedge clk);
    check(timeoutFlag == 0, "R7 reset clear", int'(timeoutFlag), 0);
    check(selCur == 3'd7, "R1 reapply", int'(selCur), 7);
    rstN = 1;
    @(negedge clk);

    // Random phase, fixed seed, checked per cycle against the model.
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 20000; i++) begin
      int r = int'($urandom_range(0, 999));
      tickEn = ($urandom_range(0, 9) < 8);
      kick = (r < 3);
      selWrEn = (r >= 995);
      selWrData = {5'($urandom), 3'($urandom_range(0, 2))};
      @(negedge clk);
    end
    tickEn = 0; kick = 0; selWrEn = 0;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    done = 1;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule